// File: doc/BRIEF.md
# DDR2 Self-Refresh Exit Sequencer

This block sits on the controller side of a DDR2 command bus and brings the memory out of self refresh in a safe order. After an exit request it keeps the clock enable low until the clock source reports that it is stable. It then raises the clock enable and forces no-operation commands onto the bus for a fixed number of cycles, so that any refresh running inside the device can finish. For the rest of the exit period it passes the controller's commands through, but keeps the clock enable high and on-die termination off. Once both intervals have expired it reports ready and hands the whole bus to normal traffic.

The block also controls re-entry into self refresh. The device may miss an internal refresh when it leaves self refresh, so it must receive one auto refresh after the exit, and that refresh must complete, before it may enter self refresh again. A re-entry request that arrives before this is held off, and the controller's traffic continues as usual in the meantime. When the request is granted, the block issues the entry command itself: a refresh with the clock enable low.

Top module: `sr_exit_seq`

## Requirements
- R1: While reset is held, and in the self-refresh state that follows it, cke is 0, the bus shows deselect (cs_n=1, ras_n=1, cas_n=1, we_n=1), and odt, ready and sr_grant are 0.
- R2: After exit_req, cke stays 0 for as long as clk_stable is low. cke rises in the cycle after the first clock edge that samples clk_stable high, counted from the cycle after the exit_req edge.
- R3: During the first T_XSNR cycles with cke high, the bus carries NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) whatever the usr_* command is. A refresh the controller requests inside this window is not counted as the extra refresh.
- R4: odt is 0 whenever ready is 0. While ready is 1 and no grant is active, odt follows usr_odt.
- R5: From the (T_XSNR+1)-th cke-high cycle up to the T_XSRD-th, the usr_* command passes to the bus unchanged and cke stays high. ready rises in the cycle after exactly T_XSRD cke-high cycles.
- R6: sr_grant is 1 only when the exit interval of R3 is over, sr_entry_req is 1, an auto refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1 on the bus with cke high) has been issued since the exit, and at least T_RFC cycles separate the latest such refresh from the grant cycle.
- R7: In a grant cycle cke is 0, the bus carries the refresh encoding of R6 and odt is 0. From the next cycle the block is in self refresh as in R1.
- R8: The record of the extra refresh is cleared on re-entry, so every exit needs a new refresh before the next grant.
- R9: While the gate of R6 is closed, sr_entry_req has no effect: cke stays high and the usr_* command reaches the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exit_req | input | 1 | Request to leave self refresh |
| clk_stable | input | 1 | Memory clock is stable |
| sr_entry_req | input | 1 | Request to enter self refresh again |
| usr_cs_n | input | 1 | Controller chip select, active low |
| usr_ras_n | input | 1 | Controller row strobe, active low |
| usr_cas_n | input | 1 | Controller column strobe, active low |
| usr_we_n | input | 1 | Controller write enable, active low |
| usr_odt | input | 1 | Controller termination request |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select to the memory |
| ras_n | output | 1 | Row strobe to the memory |
| cas_n | output | 1 | Column strobe to the memory |
| we_n | output | 1 | Write enable to the memory |
| odt | output | 1 | Termination enable to the memory |
| ready | output | 1 | Both exit intervals are over |
| sr_grant | output | 1 | Self-refresh entry issued in this cycle |

## Verification
The hardest case to reach from the ports is a re-entry request that is refused although a refresh was requested: the refresh has to be presented during the forced no-operation window, where the block hides it, and the entry request must then be raised with no later refresh. The bench drives the refresh encoding on every cycle of that window, holds sr_entry_req high after ready, and observes that cke and the passed-through command stay unchanged. It then issues a real refresh and steps through the T_RFC window cycle by cycle to locate the exact grant cycle, and repeats the exit to show that the refresh record does not survive re-entry.

// File: rtl/sr_exit_seq.sv
module sr_exit_seq #(
  parameter int T_XSNR = 8,
  parameter int T_XSRD = 20,
  parameter int T_RFC  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic exit_req,
  input  logic clk_stable,
  input  logic sr_entry_req,
  input  logic usr_cs_n,
  input  logic usr_ras_n,
  input  logic usr_cas_n,
  input  logic usr_we_n,
  input  logic usr_odt,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic odt,
  output logic ready,
  output logic sr_grant
);
  localparam int  HOLD_LEN = T_XSRD - T_XSNR;
  localparam bit  HAS_HOLD = HOLD_LEN > 0;
  localparam int  CMAX     = (T_XSRD > T_RFC) ? T_XSRD : T_RFC;
  localparam int  CW       = $clog2(CMAX + 2);

  typedef enum logic [2:0] {S_SR, S_WCLK, S_NOP, S_HOLD, S_RDY} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] rfc_cnt;
  logic          ref_done;
  logic          open_bus;
  logic          usr_ref;
  logic          ref_seen;

  assign open_bus = (st == S_HOLD) || (st == S_RDY);
  assign usr_ref  = !usr_cs_n && !usr_ras_n && !usr_cas_n && usr_we_n;
  assign sr_grant = open_bus && sr_entry_req && ref_done && (rfc_cnt == '0);
  assign ref_seen = open_bus && !sr_grant && usr_ref;
  assign cke      = ((st == S_NOP) || open_bus) && !sr_grant;
  assign ready    = (st == S_RDY);
  assign odt      = ready && !sr_grant && usr_odt;

  always_comb begin
    if (sr_grant)
      {cs_n, ras_n, cas_n, we_n} = 4'b0001;
    else if (open_bus)
      {cs_n, ras_n, cas_n, we_n} = {usr_cs_n, usr_ras_n, usr_cas_n, usr_we_n};
    else if (st == S_NOP)
      {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    else
      {cs_n, ras_n, cas_n, we_n} = 4'b1111;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_SR;
      cnt <= '0;
    end else begin
      case (st)
        S_SR:   if (exit_req) st <= S_WCLK;
        S_WCLK: if (clk_stable) begin
                  st  <= S_NOP;
                  cnt <= CW'(T_XSNR - 1);
                end
        S_NOP:  if (cnt == '0) begin
                  if (HAS_HOLD) begin
                    st  <= S_HOLD;
                    cnt <= CW'(HOLD_LEN - 1);
                  end else begin
                    st <= S_RDY;
                  end
                end else begin
                  cnt <= cnt - 1'b1;
                end
        S_HOLD: if (sr_grant)       st <= S_SR;
                else if (cnt == '0) st <= S_RDY;
                else                cnt <= cnt - 1'b1;
        S_RDY:  if (sr_grant) st <= S_SR;
        default: st <= S_SR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_done <= 1'b0;
      rfc_cnt  <= '0;
    end else begin
      if (sr_grant)      ref_done <= 1'b0;
      else if (ref_seen) ref_done <= 1'b1;
      if (ref_seen)               rfc_cnt <= CW'(T_RFC - 1);
      else if (rfc_cnt != '0)     rfc_cnt <= rfc_cnt - 1'b1;
    end
  end

  // Port-level observers for the assertions below
  logic [CW:0] hi_cyc;
  logic [CW:0] since_ref;
  logic        saw_ref;
  logic        bus_ref;
  assign bus_ref = !cs_n && !ras_n && !cas_n && we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cyc    <= '0;
      since_ref <= '0;
      saw_ref   <= 1'b0;
    end else begin
      if (!cke)                          hi_cyc <= '0;
      else if (hi_cyc != (CW+1)'(CMAX + 1)) hi_cyc <= hi_cyc + 1'b1;
      if (cke && bus_ref)                since_ref <= (CW+1)'(1);
      else if (since_ref != (CW+1)'(CMAX + 1)) since_ref <= since_ref + 1'b1;
      if (!cke)         saw_ref <= 1'b0;
      else if (bus_ref) saw_ref <= 1'b1;
    end
  end

  a_r2_cke_after_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(clk_stable));

  a_r3_nop_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && hi_cyc < T_XSNR) |-> (!cs_n && ras_n && cas_n && we_n));

  a_r4_odt_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !odt);

  a_r5_ready_span: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (hi_cyc == T_XSRD));

  a_r6_entry_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (saw_ref && since_ref >= T_RFC));

  a_r7_entry_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (bus_ref && !odt));

endmodule

// File: tb/sr_exit_seq_tb.sv
module sr_exit_seq_tb;
  localparam int T_XSNR = 8;
  localparam int T_XSRD = 20;
  localparam int T_RFC  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exit_req = 1'b0, clk_stable = 1'b0, sr_entry_req = 1'b0;
  logic usr_cs_n = 1'b1, usr_ras_n = 1'b1, usr_cas_n = 1'b1, usr_we_n = 1'b1, usr_odt = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, odt, ready, sr_grant;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sr_exit_seq #(.T_XSNR(T_XSNR), .T_XSRD(T_XSRD), .T_RFC(T_RFC)) u_dut (
    .clk(clk), .rst_n(rst_n), .exit_req(exit_req), .clk_stable(clk_stable),
    .sr_entry_req(sr_entry_req), .usr_cs_n(usr_cs_n), .usr_ras_n(usr_ras_n),
    .usr_cas_n(usr_cas_n), .usr_we_n(usr_we_n), .usr_odt(usr_odt),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .odt(odt), .ready(ready), .sr_grant(sr_grant));

  function automatic logic [3:0] bus();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive_cmd(input logic [3:0] c, input logic o);
    {usr_cs_n, usr_ras_n, usr_cas_n, usr_we_n} = c;
    usr_odt = o;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // R1: idle self-refresh state
  task automatic t_reset();
    step(); #1;
    chk("R1", "cke in reset", cke, 0);
    chk("R1", "bus in reset", bus(), 4'b1111);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(); drive_cmd(4'b0001, 1'b1); #1;
      chk("R1", "cke idle", cke, 0);
      chk("R1", "bus idle", bus(), 4'b1111);
      chk("R1", "odt idle", odt, 0);
      chk("R1", "ready idle", ready, 0);
    end
  endtask

  // R2..R5: full exit with refresh attempted inside the NOP window
  task automatic t_exit(input int stable_delay);
    step(); exit_req = 1'b1; clk_stable = 1'b0; #1;
    step(); exit_req = 1'b0;
    for (int i = 0; i < stable_delay; i++) begin
      #1; chk("R2", "cke before clk_stable", cke, 0);
      step();
    end
    clk_stable = 1'b1;
    #1; chk("R2", "cke at clk_stable edge", cke, 0);
    for (int i = 0; i < T_XSRD; i++) begin
      step();
      if (i < T_XSNR) drive_cmd(4'b0001, 1'b1);
      else            drive_cmd(4'b0011, 1'b1);
      #1;
      chk("R5", "cke high in exit", cke, 1);
      chk("R5", "ready low in exit", ready, 0);
      chk("R4", "odt low in exit", odt, 0);
      if (i < T_XSNR) chk("R3", "NOP forced", bus(), 4'b0111);
      else            chk("R5", "user cmd passes", bus(), 4'b0011);
    end
    step(); drive_cmd(4'b0111, 1'b1); #1;
    chk("R5", "ready after T_XSRD", ready, 1);
    chk("R4", "odt follows user", odt, 1);
    usr_odt = 1'b0; #1;
    chk("R4", "odt follows user low", odt, 0);
  endtask

  // R9 / R3 / R8: entry held off without a counted refresh
  task automatic t_blocked(input string req);
    step(); sr_entry_req = 1'b1; drive_cmd(4'b0011, 1'b0);
    for (int i = 0; i < 5; i++) begin
      #1;
      chk(req, "no grant without refresh", sr_grant, 0);
      chk("R9", "cke stays high", cke, 1);
      chk("R9", "user cmd reaches bus", bus(), 4'b0011);
      step();
    end
  endtask

  // R6 / R7: refresh then wait T_RFC
  task automatic t_grant();
    drive_cmd(4'b0001, 1'b0); #1;
    chk("R6", "no grant on refresh cycle", sr_grant, 0);
    chk("R6", "refresh on bus", bus(), 4'b0001);
    for (int j = 1; j <= T_RFC; j++) begin
      step(); drive_cmd(4'b0111, 1'b1); #1;
      if (j < T_RFC) begin
        chk("R6", "no grant inside tRFC", sr_grant, 0);
        chk("R9", "cke high inside tRFC", cke, 1);
      end else begin
        chk("R6", "grant after tRFC", sr_grant, 1);
        chk("R7", "cke low on grant", cke, 0);
        chk("R7", "entry cmd", bus(), 4'b0001);
        chk("R7", "odt low on grant", odt, 0);
      end
    end
    step(); sr_entry_req = 1'b0; #1;
    chk("R7", "cke low after entry", cke, 0);
    chk("R7", "deselect after entry", bus(), 4'b1111);
    chk("R7", "ready low after entry", ready, 0);
    chk("R7", "odt low after entry", odt, 0);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_exit(4);
    t_blocked("R3");
    t_grant();
    sr_entry_req = 1'b0;
    clk_stable = 1'b0;
    t_exit(0);
    t_blocked("R8");
    t_grant();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule